// File: doc/BRIEF.md
# Double-Data-Rate Output Register

This block drives one output bit that carries two data bits per clock period: one in the high half of the clock and one in the low half. It is meant to sit at the very end of a serializer or clock-forwarding path. The upstream logic supplies a first-half bit and a second-half bit. The register turns them into a single waveform that can change on both clock edges.

A parameter picks one of two capture modes.

- **Opposite-edge mode** samples the first-half bit on the rising edge and the second-half bit on the falling edge. This gives the lowest latency for the second bit.
- **Same-edge mode** samples both bits together on the rising edge. An extra falling-edge stage then presents the second bit half a period after the first. This keeps the pair aligned to a single edge, which makes upstream timing simple, but the second bit is taken half a period earlier.

Further parameters give the value the output holds before any capture and whether the active-low set and clear inputs act on clock edges or immediately. Holding the first-half bit at 1 and the second-half bit at 0 reproduces the clock on the output, so the block can also forward a clock alongside data.

Top module: `ddr_out_reg`

## Requirements
- R1: Before any capture, both internal stages hold the parameter `INIT_Q`, so `q` equals `INIT_Q` in both clock phases.
- R2: With `CAP_MODE = CAP_OPPOSITE` and `ce` high, `d_rise` is sampled at each rising edge and drives `q` while `clk` is high. `d_fall` is sampled at the next falling edge and drives `q` while `clk` is low, until the following rising edge.
- R3: With `CAP_MODE = CAP_SAME` and `ce` high, `d_rise` and `d_fall` are both sampled on the same rising edge. `q` shows the `d_rise` sample while `clk` is high, then the `d_fall` sample while `clk` is low. A change on `d_fall` after that rising edge does not reach `q` in that period.
- R4: With `d_rise` held at 1, `d_fall` held at 0 and `ce` high, `q` is 1 in every high half and 0 in every low half, in both modes.
- R5: While `ce` is low, no stage updates. `q` keeps repeating the last captured pair: the high-half value while `clk` is high and the low-half value while `clk` is low.
- R6: When `clr_n` is low, all stages are forced to 0, even if `pre_n` is low at the same time.
- R7: When `pre_n` is low and `clr_n` is high, all stages are forced to 1, whatever the values of `ce` and the data inputs.
- R8: With `SR_KIND = SR_SYNC`, set and clear take effect only at the next clock edge of each stage. With `SR_KIND = SR_ASYNC`, they take effect at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock; both of its edges are used |
| ce | input | 1 | Capture enable for all stages |
| d_rise | input | 1 | Bit presented during the high half of the clock |
| d_fall | input | 1 | Bit presented during the low half of the clock |
| pre_n | input | 1 | Active-low set; lower priority than clear |
| clr_n | input | 1 | Active-low clear; highest priority |
| q | output | 1 | Double-data-rate output |

## Verification
The case that is hardest to reach from the ports is one where the two capture modes produce different output for the same pair. For the modes to diverge, `d_fall` must change after the rising edge but before the falling edge. To do this, the stimulus drives `d_fall` twice in each cycle: once before the rising edge and once inside the high half. One table of vectors then gives distinct expected low-half values for an opposite-edge instance and a same-edge instance. The difference between synchronous and asynchronous clear is shown by dropping `clr_n` in the low half, well away from any edge, and sampling before the next rising edge.

// File: rtl/ddr_pkg.sv
// Package: ddr_pkg
// Shared parameter types for the double-data-rate output register.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ddr_pkg;

    // Which edges sample the two data inputs.
    typedef enum logic {
        CAP_OPPOSITE = 1'b0,
        CAP_SAME     = 1'b1
    } capture_mode_e;

    // How set and clear act on the stages.
    typedef enum logic {
        SR_SYNC  = 1'b0,
        SR_ASYNC = 1'b1
    } sr_kind_e;

endpackage

// File: rtl/ddr_cap_flop.sv
// Module: ddr_cap_flop
// One capture stage: a rising-edge flop with enable, active-low set and
// active-low clear (clear wins). The parameter SR_KIND picks whether set/clear
// wait for the clock edge or act immediately. The power-up value is INIT_Q.
// Assumes the caller inverts the clock for a falling-edge stage.
module ddr_cap_flop #(
    parameter logic              INIT_Q  = 1'b0,
    parameter ddr_pkg::sr_kind_e SR_KIND = ddr_pkg::SR_SYNC
) (
    input  logic cap_clk,
    input  logic ce,
    input  logic d,
    input  logic pre_n,
    input  logic clr_n,
    output logic q
);

    logic q_r = INIT_Q;

    generate
        if (SR_KIND == ddr_pkg::SR_ASYNC) begin : g_async
            // Capture stage whose set/clear bypass the clock.
            always_ff @(posedge cap_clk or negedge clr_n or negedge pre_n) begin
                if (!clr_n)      q_r <= 1'b0;
                else if (!pre_n) q_r <= 1'b1;
                else if (ce)     q_r <= d;
            end
        end else begin : g_sync
            // Capture stage whose set/clear are sampled on the clock edge.
            always_ff @(posedge cap_clk) begin
                if (!clr_n)      q_r <= 1'b0;
                else if (!pre_n) q_r <= 1'b1;
                else if (ce)     q_r <= d;
            end
        end
    endgenerate

    assign q = q_r;

    // R2/R3: an enabled edge loads the data seen at that edge.
    p_capture_r2: assert property (@(posedge cap_clk) disable iff (!clr_n || !pre_n)
        ce |=> (q == $past(d)));

    // R5: a disabled edge leaves the stage untouched.
    p_hold_idle_r5: assert property (@(posedge cap_clk) disable iff (!clr_n || !pre_n)
        !ce |=> $stable(q));

    // R7: set seen at an edge leaves the stage at 1.
    p_set_level_r7: assert property (@(posedge cap_clk) disable iff (!clr_n)
        !pre_n |=> (q == 1'b1));

endmodule

// File: rtl/ddr_phase_mux.sv
// Module: ddr_phase_mux
// Selects the high-half stage while the clock is high and the low-half stage
// while it is low. Assumes both stage outputs settle within their own half.
module ddr_phase_mux (
    input  logic clk,
    input  logic hi,
    input  logic lo,
    output logic q
);

    // Phase select: clock level chooses which stage reaches the pin.
    always_comb begin
        q = clk ? hi : lo;
    end

endmodule

// File: rtl/ddr_out_reg.sv
// Module: ddr_out_reg
// Double-data-rate output register. A rising-edge stage holds the high-half
// bit; a falling-edge stage holds the low-half bit. In same-edge mode an extra
// rising-edge stage samples d_fall alongside d_rise and hands it to the
// falling-edge stage. Assumes a free-running clk and inputs that meet setup to
// the edge that samples them.
module ddr_out_reg #(
    parameter ddr_pkg::capture_mode_e CAP_MODE = ddr_pkg::CAP_OPPOSITE,
    parameter logic                   INIT_Q   = 1'b0,
    parameter ddr_pkg::sr_kind_e      SR_KIND  = ddr_pkg::SR_SYNC
) (
    input  logic clk,
    input  logic ce,
    input  logic d_rise,
    input  logic d_fall,
    input  logic pre_n,
    input  logic clr_n,
    output logic q
);

    logic clk_fall;
    logic hi_q;
    logic lo_q;
    logic lo_d;

    assign clk_fall = ~clk;

    // High-half stage, sampled on the rising edge.
    ddr_cap_flop #(.INIT_Q(INIT_Q), .SR_KIND(SR_KIND)) u_hi (
        .cap_clk (clk),
        .ce      (ce),
        .d       (d_rise),
        .pre_n   (pre_n),
        .clr_n   (clr_n),
        .q       (hi_q)
    );

    generate
        if (CAP_MODE == ddr_pkg::CAP_SAME) begin : g_same
            logic pend_q;
            // Pairing stage: d_fall sampled on the same rising edge as d_rise.
            ddr_cap_flop #(.INIT_Q(INIT_Q), .SR_KIND(SR_KIND)) u_pend (
                .cap_clk (clk),
                .ce      (ce),
                .d       (d_fall),
                .pre_n   (pre_n),
                .clr_n   (clr_n),
                .q       (pend_q)
            );
            assign lo_d = pend_q;
        end else begin : g_opposite
            assign lo_d = d_fall;
        end
    endgenerate

    // Low-half stage, sampled on the falling edge.
    ddr_cap_flop #(.INIT_Q(INIT_Q), .SR_KIND(SR_KIND)) u_lo (
        .cap_clk (clk_fall),
        .ce      (ce),
        .d       (lo_d),
        .pre_n   (pre_n),
        .clr_n   (clr_n),
        .q       (lo_q)
    );

    ddr_phase_mux u_mux (
        .clk (clk),
        .hi  (hi_q),
        .lo  (lo_q),
        .q   (q)
    );

    // R5: enable low across two rising edges keeps the whole pair frozen.
    p_pair_hold_r5: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
        (!ce ##1 !ce) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: tb/ddr_out_reg_tb.sv
module ddr_out_reg_tb;
    import ddr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {ce, d_rise, d_fall_early, d_fall_late, opp_hi, opp_lo, same_hi, same_lo}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_1_0_0_1_0_1_0,
        8'b1_0_1_1_0_1_0_1,
        8'b1_1_1_0_1_0_1_1,
        8'b1_0_0_1_0_1_0_0,
        8'b0_1_1_0_0_1_0_0,
        8'b0_0_0_1_0_1_0_0,
        8'b1_1_0_0_1_0_1_0,
        8'b1_1_0_0_1_0_1_0,
        8'b1_1_1_1_1_1_1_1,
        8'b1_0_0_0_0_0_0_0
    };

    logic clk = 1'b0;
    logic ce = 1'b0, d_rise = 1'b0, d_fall = 1'b0, pre_n = 1'b1, clr_n = 1'b1;
    logic q_opp, q_same, q_async;
    int   checks = 0, errors = 0;
    bit   done = 0;
    logic [2:0] smp_hi, smp_lo;   // {async, same, opp}

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_out_reg #(.CAP_MODE(CAP_OPPOSITE), .INIT_Q(1'b0), .SR_KIND(SR_SYNC)) u_dut (
        .clk(clk), .ce(ce), .d_rise(d_rise), .d_fall(d_fall),
        .pre_n(pre_n), .clr_n(clr_n), .q(q_opp));
    ddr_out_reg #(.CAP_MODE(CAP_SAME), .INIT_Q(1'b0), .SR_KIND(SR_SYNC)) u_dut_same (
        .clk(clk), .ce(ce), .d_rise(d_rise), .d_fall(d_fall),
        .pre_n(pre_n), .clr_n(clr_n), .q(q_same));
    ddr_out_reg #(.CAP_MODE(CAP_OPPOSITE), .INIT_Q(1'b1), .SR_KIND(SR_ASYNC)) u_dut_async (
        .clk(clk), .ce(ce), .d_rise(d_rise), .d_fall(d_fall),
        .pre_n(pre_n), .clr_n(clr_n), .q(q_async));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Called 2 time units before a rising edge P: drives inputs, moves d_fall
    // at P+2, samples the high half at P+3 and the low half at P+7.
    task automatic run_cycle(input logic c, input logic dr, input logic dfe,
                             input logic dfl, input logic clr_v, input logic pre_v);
        ce = c; d_rise = dr; d_fall = dfe; clr_n = clr_v; pre_n = pre_v;
        #4;
        d_fall = dfl;
        #1;
        smp_hi = {q_async, q_same, q_opp};
        #4;
        smp_lo = {q_async, q_same, q_opp};
        #1;
    endtask

    initial begin
        #(CLK_PERIOD*400);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2;
        check("R1 opp init", q_opp, 1'b0);
        check("R1 same init", q_same, 1'b0);
        check("R1 async init", q_async, 1'b1);
        #1;
        for (int i = 0; i < 2; i++) begin
            run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
            check("R1/R5 init held hi", smp_hi[2], 1'b1);
            check("R1/R5 init held lo", smp_lo[2], 1'b1);
            check("R1/R5 opp held", smp_hi[0] | smp_lo[0], 1'b0);
        end
        // Clear, then clear together with set: R6
        run_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R6 clear hi", |smp_hi, 1'b0);
        check("R6 clear lo", |smp_lo, 1'b0);
        run_cycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 clear beats set hi", |smp_hi, 1'b0);
        check("R6 clear beats set lo", |smp_lo, 1'b0);

        // Vector table: R2 (opposite), R3 (same), R5 (ce low rows)
        for (int v = 0; v < NVEC; v++) begin
            run_cycle(VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], 1'b1, 1'b1);
            check($sformatf("R2 opp hi v%0d", v),   smp_hi[0], VEC[v][3]);
            check($sformatf("R2 opp lo v%0d", v),   smp_lo[0], VEC[v][2]);
            check($sformatf("R3 same hi v%0d", v),  smp_hi[1], VEC[v][1]);
            check($sformatf("R3 same lo v%0d", v),  smp_lo[1], VEC[v][0]);
            check($sformatf("R2 async hi v%0d", v), smp_hi[2], VEC[v][3]);
            check($sformatf("R2 async lo v%0d", v), smp_lo[2], VEC[v][2]);
        end

        // R4: clock forwarding, q follows clk in both modes
        for (int k = 0; k < 3; k++) begin
            run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
            check("R4 fwd opp hi", smp_hi[0], 1'b1);
            check("R4 fwd opp lo", smp_lo[0], 1'b0);
            check("R4 fwd same hi", smp_hi[1], 1'b1);
            check("R4 fwd same lo", smp_lo[1], 1'b0);
        end

        // R7: set overrides data and enable
        run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 set hi", &smp_hi, 1'b1);
        check("R7 set lo", &smp_lo, 1'b1);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 set with ce low", &smp_lo, 1'b1);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R5 after set held", &smp_lo, 1'b1);

        // R8: clear dropped in the low half, away from any edge
        clr_n = 1'b0;
        #1;
        check("R8 async clears at once", q_async, 1'b0);
        check("R8 sync waits for edge", q_opp, 1'b1);
        check("R8 sync same waits", q_same, 1'b1);
        #4;
        check("R8 sync hi cleared at edge", q_opp, 1'b0);
        #4;
        check("R8 sync lo cleared at edge", q_opp, 1'b0);
        check("R8 same lo cleared", q_same, 1'b0);
        #1;
        clr_n = 1'b1;
        #(CLK_PERIOD*2);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule